// File: doc/BRIEF.md
# Burst Address Sequence Slave

This block is a memory-backed slave for precise-length bursts in which every beat arrives as a complete request with its own address. The first beat of a burst fixes the burst length and the address sequence. Three sequences are supported: incrementing, wrapping and streaming, where every beat uses the same address. Each later beat is compared with the address that the sequence predicts. Beats that pass are serviced against an internal word memory. Beats that fail get an error response and change nothing in the memory.

Every accepted beat produces exactly one response. A one-entry response register holds that response until the master accepts it. While a response is waiting, new requests are refused, so the register can never be overwritten. The master marks the final beat of a burst with a last-request flag. The slave marks the response that ends its own view of the burst with a last-response flag.

Top module: `burst_seq_slave`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `cmd_accept` is 1.
- R2: With `req_seq` = 0 (incrementing), each beat after the first must be one word (4 bytes by default) above the previous beat. Writes store `req_wdata`, and reads return the stored word with `rsp_err` = 0.
- R3: With `req_seq` = 1 (wrapping), the burst length is a power of two. The address steps up one word at a time and wraps inside a window of length × word bytes that is aligned to its own size.
- R4: With `req_seq` = 2 (streaming), every beat must use the address of the first beat. Writes to that word are applied in order, and reads return its current value.
- R5: A beat whose address differs from the predicted address gets `rsp_err` = 1 and `rsp_data` = 0, and it does not write the memory. The tracker keeps advancing along the predicted sequence.
- R6: `req_len` encodes the number of beats minus one and is taken from the first beat only. A beat whose `req_last` does not match "this is beat number `req_len`" gets `rsp_err` = 1 and ends the tracked burst. The next beat then starts a new burst.
- R7: `rsp_last` is 1 on the response of any beat that ends the tracked burst: either the beat numbered `req_len`, or any beat that carries `req_last`.
- R8: While `rsp_valid` is 1 and `rsp_accept` is 0, `cmd_accept` is 0, and `rsp_data`, `rsp_err` and `rsp_last` hold steady.
- R9: A request taken on a clock edge (`req_valid` and `cmd_accept` both high) shows up as `rsp_valid` = 1 right after that edge. With `rsp_accept` held high, one beat per cycle is accepted.
- R10: A first beat gets `rsp_err` = 1 and does not write the memory in any of these cases: its address is not word aligned, `req_seq` = 3, or `req_seq` = 1 with a length that is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Beat request present |
| req_write | input | 1 | 1 = write beat, 0 = read beat |
| req_addr | input | AW (8) | Byte address of this beat |
| req_wdata | input | DW (32) | Write data of this beat |
| req_len | input | LW (4) | Beats in burst minus one (used on first beat) |
| req_seq | input | 2 | 0 incrementing, 1 wrapping, 2 streaming, 3 reserved |
| req_last | input | 1 | Master marks final beat of the burst |
| cmd_accept | output | 1 | Slave takes the beat on this edge |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DW (32) | Read data, 0 for writes and errors |
| rsp_err | output | 1 | Beat was rejected |
| rsp_last | output | 1 | Response ends the tracked burst |
| rsp_accept | input | 1 | Master takes the response |

## Verification
Each beat's response is registered on the edge that accepts the beat, so it is visible one edge after acceptance. The bench checks `rsp_valid` at the falling edge that follows every acceptance. Responses are scored at the falling edge of each cycle in which `rsp_valid` and `rsp_accept` are both high, and this keeps the scoring aligned with the edge on which the master takes the response. `rsp_accept` changes only at rising edges, so a stalled response can be compared between consecutive falling edges to confirm that it is held for R8.

// File: rtl/burst_seq_slave.sv
module burst_seq_slave #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [LW-1:0] req_len,
  input  logic [1:0]    req_seq,
  input  logic          req_last,
  output logic          cmd_accept,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          rsp_last,
  input  logic          rsp_accept
);
  localparam int BL    = $clog2(DW/8);
  localparam int WA    = AW - BL;
  localparam int DEPTH = 1 << WA;

  logic [DW-1:0] mem [DEPTH];

  logic          trk_active;
  logic [LW-1:0] trk_cnt, trk_len;
  logic [1:0]    trk_seq;
  logic [WA-1:0] trk_next;

  logic          first, is_final, closes, fire, pow2, misalign;
  logic          addr_bad, last_bad, beat_err;
  logic [LW-1:0] len_cur, beat_idx;
  logic [LW:0]   len_p1;
  logic [1:0]    seq_cur;
  logic [WA-1:0] word, base_w, next_w, mask_w;

  assign first    = !trk_active;
  assign len_cur  = first ? req_len : trk_len;
  assign seq_cur  = first ? req_seq : trk_seq;
  assign beat_idx = first ? '0 : trk_cnt + 1'b1;
  assign is_final = (beat_idx == len_cur);
  assign closes   = is_final | req_last;
  assign word     = req_addr[AW-1:BL];
  assign base_w   = first ? word : trk_next;
  assign mask_w   = WA'(len_cur);

  assign len_p1   = {1'b0, len_cur} + 1'b1;
  assign pow2     = ((len_p1 & {1'b0, len_cur}) == '0);
  assign misalign = |req_addr[BL-1:0];

  assign addr_bad = first ? (misalign || req_seq == 2'd3 || (req_seq == 2'd1 && !pow2))
                          : (req_addr != {trk_next, {BL{1'b0}}});
  assign last_bad = (req_last != is_final);
  assign beat_err = addr_bad | last_bad;

  always_comb begin
    case (seq_cur)
      2'd0:    next_w = base_w + 1'b1;
      2'd1:    next_w = (base_w & ~mask_w) | ((base_w + 1'b1) & mask_w);
      default: next_w = base_w;
    endcase
  end

  assign cmd_accept = !rsp_valid | rsp_accept;
  assign fire       = req_valid & cmd_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_active <= 1'b0;
      trk_cnt    <= '0;
      trk_len    <= '0;
      trk_seq    <= '0;
      trk_next   <= '0;
    end else if (fire) begin
      trk_active <= !closes;
      trk_cnt    <= beat_idx;
      trk_next   <= next_w;
      if (first) begin
        trk_len <= req_len;
        trk_seq <= req_seq;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fire && req_write && !beat_err)
      mem[word] <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_last  <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= (!req_write && !beat_err) ? mem[word] : '0;
      rsp_err   <= beat_err;
      rsp_last  <= closes;
    end else if (rsp_accept) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_seq_slave_chk.sv
module burst_seq_slave_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          cmd_accept,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_err,
  input logic          rsp_last,
  input logic          rsp_accept,
  input logic          trk_active
);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_accept |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err) && $stable(rsp_last));

  // R8
  stall_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_accept |-> !cmd_accept);

  // R9
  rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cmd_accept |=> rsp_valid);

  // R9
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && cmd_accept));

  // R7
  last_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_last |-> !trk_active);

  // R6
  open_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_last |-> trk_active);
endmodule

bind burst_seq_slave burst_seq_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cmd_accept(cmd_accept),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
  .rsp_last(rsp_last), .rsp_accept(rsp_accept), .trk_active(trk_active)
);

// File: tb/tb_burst_seq_slave.sv
`timescale 1ns/1ps
module tb_burst_seq_slave;
  localparam int AW = 8, DW = 32, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_last = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [LW-1:0] req_len = '0;
  logic [1:0] req_seq = '0;
  logic cmd_accept, rsp_valid, rsp_err, rsp_last;
  logic [DW-1:0] rsp_data;
  logic rsp_accept = 1'b1;
  logic bp_mode = 1'b0;
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  logic [DW-1:0] sm [64];
  logic [DW+1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  burst_seq_slave #(.AW(AW), .DW(DW), .LW(LW)) dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_accept <= !bp_mode || (cyc % 3 != 0);
  end

  task automatic chk(input bit ok, input string req, input string msg, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  task automatic beat(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [LW-1:0] len, input logic [1:0] seq, input bit last,
                      input bit e_err, input bit e_last, input string tag);
    logic [DW-1:0] e_data;
    e_data = (!w && !e_err) ? sm[a[AW-1:2]] : '0;
    exp_q.push_back({e_data, e_err, e_last});
    tag_q.push_back(tag);
    if (w && !e_err) sm[a[AW-1:2]] = d;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    req_len = len; req_seq = seq; req_last = last;
    forever begin
      #1;
      if (cmd_accept) begin @(posedge clk); break; end
      @(negedge clk);
    end
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R9", "response one edge after accept", rsp_valid, 1);
    req_valid = 1'b0;
  endtask

  logic hold = 0;
  logic [DW+1:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold)
        chk(rsp_valid === 1'b1 && {rsp_data, rsp_err, rsp_last} === held, "R8",
            "stalled response held", {rsp_valid, rsp_data, rsp_err, rsp_last}, {1'b1, held});
      hold = 0;
      if (rsp_valid && !rsp_accept) begin
        chk(cmd_accept === 1'b0, "R8", "cmd_accept low during stall", cmd_accept, 0);
        hold = 1;
        held = {rsp_data, rsp_err, rsp_last};
      end
      if (rsp_valid && rsp_accept) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected response", {rsp_data, rsp_err, rsp_last}, 0);
        end else begin
          logic [DW+1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({rsp_data, rsp_err, rsp_last} === e, t, "response {data,err,last}",
              {rsp_data, rsp_err, rsp_last}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0 && cmd_accept === 1'b1, "R1", "reset state",
        {rsp_valid, cmd_accept}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 incrementing write then read, back to back
    for (int i = 0; i < 4; i++)
      beat(1, 8'h10 + 8'(4*i), 32'hA000 + i, 3, 0, i == 3, 0, i == 3, "R2");
    for (int i = 0; i < 4; i++)
      beat(0, 8'h10 + 8'(4*i), 0, 3, 0, i == 3, 0, i == 3, "R7");

    // R3 wrapping: window 0x20..0x2F, start at 0x28
    beat(1, 8'h28, 32'hB0, 3, 1, 0, 0, 0, "R3");
    beat(1, 8'h2C, 32'hB1, 3, 1, 0, 0, 0, "R3");
    beat(1, 8'h20, 32'hB2, 3, 1, 0, 0, 0, "R3");
    beat(1, 8'h24, 32'hB3, 3, 1, 1, 0, 1, "R3");
    for (int i = 0; i < 4; i++)
      beat(0, 8'h20 + 8'(4*i), 0, 3, 0, i == 3, 0, i == 3, "R3");

    bp_mode = 1'b1;
    beat(0, 8'h24, 0, 3, 1, 0, 0, 0, "R3");
    beat(0, 8'h28, 0, 3, 1, 0, 0, 0, "R3");
    beat(0, 8'h2C, 0, 3, 1, 0, 0, 0, "R3");
    beat(0, 8'h20, 0, 3, 1, 1, 0, 1, "R3");

    // R4 streaming
    beat(1, 8'h40, 32'hC0, 2, 2, 0, 0, 0, "R4");
    beat(1, 8'h40, 32'hC1, 2, 2, 0, 0, 0, "R4");
    beat(1, 8'h40, 32'hC2, 2, 2, 1, 0, 1, "R4");
    beat(0, 8'h40, 0, 1, 2, 0, 0, 0, "R4");
    beat(0, 8'h40, 0, 1, 2, 1, 0, 1, "R4");

    // R5 address mismatch
    beat(1, 8'h58, 32'h1111, 0, 0, 1, 0, 1, "R5");
    beat(1, 8'h50, 32'h5050, 1, 0, 0, 0, 0, "R5");
    beat(1, 8'h58, 32'h2222, 1, 0, 1, 1, 1, "R5");
    beat(0, 8'h58, 0, 0, 0, 1, 0, 1, "R5");
    beat(0, 8'h50, 0, 1, 0, 0, 0, 0, "R5");
    beat(0, 8'h58, 0, 1, 0, 1, 1, 1, "R5");

    // R6 early and late last
    beat(0, 8'h10, 0, 3, 0, 1, 1, 1, "R6");
    beat(1, 8'h60, 32'h6060, 0, 0, 1, 0, 1, "R6");
    beat(1, 8'h64, 32'h6464, 0, 0, 0, 1, 1, "R6");
    beat(1, 8'h70, 32'h7070, 0, 0, 1, 0, 1, "R6");
    beat(0, 8'h60, 0, 0, 0, 1, 0, 1, "R6");

    // R10 illegal first beats
    beat(1, 8'h30, 32'h3030, 0, 0, 1, 0, 1, "R10");
    beat(1, 8'h20, 32'hDEAD, 2, 1, 1, 1, 1, "R10");
    beat(1, 8'h20, 32'hBEEF, 0, 3, 1, 1, 1, "R10");
    beat(1, 8'h31, 32'hFACE, 0, 0, 1, 1, 1, "R10");
    beat(0, 8'h20, 0, 0, 0, 1, 0, 1, "R10");
    beat(0, 8'h30, 0, 0, 0, 1, 0, 1, "R10");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule